// File: doc/BRIEF.md
# I2C Serial Memory Read Sequencer

This block handles reads for an I2C slave serial memory. A bit-level front end turns bus activity into single-cycle events: start (or repeated start), stop, a completed 8-bit byte, and the master acknowledge sampled in the ninth clock slot. The block answers each event. It tells the front end when to acknowledge a received byte, and it provides the next byte to shift out, most significant bit first.

The block holds a byte address counter and a small synchronous storage array. Three read forms are supported:

- **Random read.** The master sends a write header and a word address, with no stop. It then sends a repeated start and a read header.
- **Current address read.** The master sends only a read header, which uses the counter as it stands.
- **Sequential read.** The master acknowledges each byte and keeps reading.

Each byte sent advances the counter, and the counter wraps past the top address. A master NoACK, a stop, or a start that arrives mid-operation returns the sequencer to idle. Write programming timing and pin electrical behaviour are not part of this block.

Top module: `serial_mem_reader`

## Requirements
- R1: After reset, `ackEn` and `txValid` are 0, the address counter is 0, and the array holds the byte (29*a+7) mod 256 at each address a.
- R2: After a start, the first byte is a device select code. Its top four bits must equal `DEV_TYPE` and the next three must equal `strapPins`. On a match, `ackEn` is 1 for exactly the one cycle after the byte event. On a mismatch, `ackEn` stays 0 and the block goes idle. While idle, later bytes are not acknowledged until a new start.
- R3: A matching header with bit 0 = 0 is a write header. The next byte is acknowledged, and its low `ADDR_W` bits are loaded into the address counter.
- R4: After that address load, a repeated start and a matching header with bit 0 = 1 start a read. The read presents the byte at the loaded address.
- R5: A matching header with bit 0 = 1 raises `txValid` in the cycle after the byte event. In that cycle, `txByte` holds the byte at the counter, and the counter advances by one.
- R6: While `txValid` is 1, a master acknowledge event with `mackLow` = 1 presents the byte at the next address in the cycle after the event.
- R7: After the top address (2^ADDR_W - 1), the counter wraps, and output continues from address 0.
- R8: A master acknowledge event with `mackLow` = 0 clears `txValid` in the next cycle and sends the block idle. Later bytes and acknowledge events have no effect until a start.
- R9: A start received during an operation aborts it and clears `txValid`. The counter keeps its last advanced value.
- R10: A stop clears `txValid` in the next cycle and returns the block to idle. The counter keeps its value.
- R11: A byte that follows the word address of a write header (a write data byte) is not acknowledged, and the block goes idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strapPins | input | 3 | Strap bits matched against device select bits 3:1 |
| evStart | input | 1 | One-cycle start / repeated start event |
| evStop | input | 1 | One-cycle stop event |
| evByte | input | 1 | One-cycle event: a full byte was received |
| rxByte | input | 8 | Received byte, valid with `evByte` |
| evMack | input | 1 | One-cycle event: master acknowledge slot sampled |
| mackLow | input | 1 | SDA level in the acknowledge slot was low (ACK) |
| ackEn | output | 1 | Slave acknowledge enable for the byte just received |
| txByte | output | 8 | Byte to shift out, MSB first |
| txValid | output | 1 | `txByte` is being sent |

## Verification
The bench builds the block with `ADDR_W` = 4, which gives a 16-byte array. A sequential read therefore crosses the wrap from address 15 to 0 after a few bytes. The word address bytes also carry upper bits that the 4-bit counter must drop. `DEV_TYPE` stays at its default, and `strapPins` is tied to 3'b101, so the bench can build both matching and mismatching headers. A behavioural model is compared against the outputs in every clock.

// File: rtl/smr_pkg.sv
package smr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_WADDR,
    ST_WDATA,
    ST_SEND
  } seqState_t;

  typedef struct packed {
    logic loadAddr;
    logic fetch;
    logic dropTx;
  } ctlStrobes_t;

endpackage

// File: rtl/smr_ctrl.sv
module smr_ctrl
  import smr_pkg::*;
#(
  parameter logic [3:0] DEV_TYPE = 4'b1010
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  strapPins,
  input  logic        evStart,
  input  logic        evStop,
  input  logic        evByte,
  input  logic [7:0]  rxByte,
  input  logic        evMack,
  input  logic        mackLow,
  output ctlStrobes_t ctl,
  output logic        ackEn
);

  seqState_t state, stateNxt;
  logic      ackNxt;
  logic      selMatch;

  assign selMatch = (rxByte[7:1] == {DEV_TYPE, strapPins});

  always_comb begin
    stateNxt = state;
    ctl      = '0;
    ackNxt   = 1'b0;
    if (evStart) begin
      stateNxt   = ST_HDR;
      ctl.dropTx = 1'b1;
    end else if (evStop) begin
      stateNxt   = ST_IDLE;
      ctl.dropTx = 1'b1;
    end else if (evByte) begin
      case (state)
        ST_HDR: begin
          if (selMatch) begin
            ackNxt = 1'b1;
            if (rxByte[0]) begin
              ctl.fetch = 1'b1;
              stateNxt  = ST_SEND;
            end else begin
              stateNxt = ST_WADDR;
            end
          end else begin
            stateNxt = ST_IDLE;
          end
        end
        ST_WADDR: begin
          ctl.loadAddr = 1'b1;
          ackNxt       = 1'b1;
          stateNxt     = ST_WDATA;
        end
        ST_WDATA: stateNxt = ST_IDLE;
        default:  stateNxt = state;
      endcase
    end else if (evMack && state == ST_SEND) begin
      if (mackLow) begin
        ctl.fetch = 1'b1;
      end else begin
        ctl.dropTx = 1'b1;
        stateNxt   = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      ackEn <= 1'b0;
    end else begin
      state <= stateNxt;
      ackEn <= ackNxt;
    end
  end

endmodule

// File: rtl/smr_datapath.sv
module smr_datapath
  import smr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobes_t       ctl,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [7:0]        txByte,
  output logic              txValid
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0]        memArr [DEPTH];
  logic [ADDR_W-1:0] addrCnt;

  // Storage array, preset at reset with a fixed address-derived pattern.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) memArr[i] <= 8'((i * 29) + 7);
    end
  end

  // The counter advances on every fetch; the add wraps naturally at DEPTH.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrCnt <= '0;
    end else if (ctl.loadAddr) begin
      addrCnt <= addrIn;
    end else if (ctl.fetch) begin
      addrCnt <= addrCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txByte  <= '0;
      txValid <= 1'b0;
    end else if (ctl.fetch) begin
      txByte  <= memArr[addrCnt];
      txValid <= 1'b1;
    end else if (ctl.dropTx) begin
      txValid <= 1'b0;
    end
  end

endmodule

// File: rtl/serial_mem_reader.sv
module serial_mem_reader #(
  parameter int         ADDR_W   = 8,
  parameter logic [3:0] DEV_TYPE = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] strapPins,
  input  logic       evStart,
  input  logic       evStop,
  input  logic       evByte,
  input  logic [7:0] rxByte,
  input  logic       evMack,
  input  logic       mackLow,
  output logic       ackEn,
  output logic [7:0] txByte,
  output logic       txValid
);

  smr_pkg::ctlStrobes_t ctl;

  smr_ctrl #(.DEV_TYPE(DEV_TYPE)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .strapPins (strapPins),
    .evStart   (evStart),
    .evStop    (evStop),
    .evByte    (evByte),
    .rxByte    (rxByte),
    .evMack    (evMack),
    .mackLow   (mackLow),
    .ctl       (ctl),
    .ackEn     (ackEn)
  );

  smr_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl     (ctl),
    .addrIn  (rxByte[ADDR_W-1:0]),
    .txByte  (txByte),
    .txValid (txValid)
  );

endmodule

// File: rtl/serial_mem_reader_chk.sv
module serial_mem_reader_chk (
  input logic clk,
  input logic rst_n,
  input logic evStart,
  input logic evStop,
  input logic evByte,
  input logic evMack,
  input logic mackLow,
  input logic ackEn,
  input logic txValid
);

  assert_ack_after_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ackEn |-> $past(evByte));

  assert_tx_rise_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txValid) |-> ($past(evByte) || $past(evMack)));

  assert_ack_continues_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (txValid && evMack && mackLow && !evStart && !evStop) |=> txValid);

  assert_nack_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (txValid && evMack && !mackLow) |=> !txValid);

  assert_start_aborts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evStart |=> (!txValid && !ackEn));

  assert_stop_idles_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evStop |=> (!txValid && !ackEn));

endmodule

bind serial_mem_reader serial_mem_reader_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .evStart (evStart),
  .evStop  (evStop),
  .evByte  (evByte),
  .evMack  (evMack),
  .mackLow (mackLow),
  .ackEn   (ackEn),
  .txValid (txValid)
);

// File: tb/serial_mem_reader_bench.sv
`timescale 1ns/1ps
module serial_mem_reader_bench;

  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] RD_HDR = {4'b1010, STRAP, 1'b1};
  localparam logic [7:0] WR_HDR = {4'b1010, STRAP, 1'b0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evStart = 1'b0, evStop = 1'b0, evByte = 1'b0, evMack = 1'b0, mackLow = 1'b0;
  logic [7:0] rxByte = 8'h00;
  logic ackEn, txValid;
  logic [7:0] txByte;

  int checks = 0;
  int errors = 0;
  bit checking = 1'b0;
  string curReq = "R1";

  always #4 clk = ~clk;

  serial_mem_reader #(.ADDR_W(AW)) u_serial_mem_reader (
    .clk(clk), .rst_n(rst_n), .strapPins(STRAP),
    .evStart(evStart), .evStop(evStop), .evByte(evByte), .rxByte(rxByte),
    .evMack(evMack), .mackLow(mackLow),
    .ackEn(ackEn), .txByte(txByte), .txValid(txValid)
  );

  function automatic int memAt(int a);
    return ((a * 29) + 7) % 256;
  endfunction

  // Behavioural reference: 0 idle, 1 header, 2 word addr, 3 write data, 4 sending
  int  mSt = 0, mCnt = 0, mByte = 0;
  bit  mTv = 1'b0, mAck = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mSt = 0; mCnt = 0; mTv = 1'b0; mAck = 1'b0;
    end else begin
      mAck = 1'b0;
      if (evStart) begin
        mSt = 1; mTv = 1'b0;
      end else if (evStop) begin
        mSt = 0; mTv = 1'b0;
      end else if (evByte) begin
        if (mSt == 1) begin
          if (int'(rxByte) / 2 == int'(RD_HDR) / 2) begin
            mAck = 1'b1;
            if (rxByte[0]) begin
              mByte = memAt(mCnt); mCnt = (mCnt + 1) % DEPTH; mTv = 1'b1; mSt = 4;
            end else mSt = 2;
          end else mSt = 0;
        end else if (mSt == 2) begin
          mCnt = int'(rxByte) % DEPTH; mAck = 1'b1; mSt = 3;
        end else if (mSt == 3) begin
          mSt = 0;
        end
      end else if (evMack && mSt == 4) begin
        if (mackLow) begin
          mByte = memAt(mCnt); mCnt = (mCnt + 1) % DEPTH;
        end else begin
          mTv = 1'b0; mSt = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (checking) begin
      checks++;
      if (ackEn !== mAck) begin
        errors++;
        $display("FAIL %s: ackEn act=%0d exp=%0d", curReq, ackEn, mAck);
      end
      checks++;
      if (txValid !== mTv) begin
        errors++;
        $display("FAIL %s: txValid act=%0d exp=%0d", curReq, txValid, mTv);
      end
      if (mTv) begin
        checks++;
        if (int'(txByte) !== mByte) begin
          errors++;
          $display("FAIL %s: txByte act=%02h exp=%02h", curReq, txByte, mByte);
        end
      end
    end
  end

  task automatic gap();
    @(negedge clk);
  endtask
  task automatic doStart();
    @(negedge clk); evStart = 1'b1; @(negedge clk); evStart = 1'b0; gap();
  endtask
  task automatic doStop();
    @(negedge clk); evStop = 1'b1; @(negedge clk); evStop = 1'b0; gap();
  endtask
  task automatic sendByte(input logic [7:0] b);
    @(negedge clk); evByte = 1'b1; rxByte = b; @(negedge clk); evByte = 1'b0; gap();
  endtask
  task automatic masterAck(input bit low);
    @(negedge clk); evMack = 1'b1; mackLow = low; @(negedge clk); evMack = 1'b0; gap();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run act=hung exp=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    curReq = "R1";
    checks++;
    if (ackEn !== 1'b0 || txValid !== 1'b0) begin
      errors++;
      $display("FAIL R1: reset ack/tx act=%0d/%0d exp=0/0", ackEn, txValid);
    end
    checking = 1'b1;

    // R1 / R5: current read from counter 0 after reset
    curReq = "R5";
    doStart(); sendByte(RD_HDR); masterAck(1'b0); doStop();

    // R3 / R4: random read of address 5 via dummy write, upper address bits dropped
    curReq = "R3";
    doStart(); sendByte(WR_HDR); sendByte(8'h25);
    curReq = "R4";
    doStart(); sendByte(RD_HDR);
    curReq = "R6";
    masterAck(1'b1); masterAck(1'b1); masterAck(1'b0); doStop();

    // R7: sequential read across the top address
    curReq = "R7";
    doStart(); sendByte(WR_HDR); sendByte(8'h0E); doStart(); sendByte(RD_HDR);
    for (int k = 0; k < 4; k++) masterAck(1'b1);
    masterAck(1'b0); doStop();

    // R2: mismatching headers and bytes while idle
    curReq = "R2";
    doStart(); sendByte(8'hA3); sendByte(RD_HDR); doStop();
    doStart(); sendByte(8'h1B); sendByte(WR_HDR);
    doStart(); sendByte(8'hAD); doStop();

    // R8: NoACK then stray traffic without a start
    curReq = "R8";
    doStart(); sendByte(RD_HDR); masterAck(1'b0);
    masterAck(1'b1); sendByte(RD_HDR); sendByte(8'h03); doStop();

    // R9: start in the middle of a read; counter keeps its advanced value
    curReq = "R9";
    doStart(); sendByte(RD_HDR); masterAck(1'b1);
    doStart(); sendByte(RD_HDR); masterAck(1'b0); doStop();

    // R10: stop in the middle of a read, then current read resumes
    curReq = "R10";
    doStart(); sendByte(RD_HDR); doStop();
    masterAck(1'b1);
    doStart(); sendByte(RD_HDR); masterAck(1'b0); doStop();

    // R11: write data byte after the word address is not acknowledged
    curReq = "R11";
    doStart(); sendByte(WR_HDR); sendByte(8'h03); sendByte(8'h77);
    sendByte(RD_HDR);
    doStart(); sendByte(RD_HDR); masterAck(1'b0); doStop();

    repeat (3) gap();
    checking = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule